// File: doc/BRIEF.md
# Serial Packet Transmitter with Bit Stuffing and NRZI Line Coding

This block turns one packet at a time into a serial line stream of the kind a low-level serial bus host or device sends. A packet starts with a one-cycle `pkt_start` request that carries a 4-bit packet type and a 2-bit packet class. The block then sends a fixed synchronisation pattern and a packet-identifier byte built from the type. After those come the payload bits, taken from a byte stream with a ready/valid handshake, and last a check code over the payload only. Token packets get a 5-bit code. Data packets get a 16-bit code. Handshake packets carry neither payload nor code.

The serial bits are bit-stuffed and NRZI coded onto a single-ended line output. The line is qualified by an output-enable and an explicit single-ended-zero flag. Every packet ends with a fixed end-of-packet pattern, after which the line returns to the idle level. One line symbol lasts `BIT_DIV` clock cycles. The block accepts a new packet whenever `pkt_rdy` is high.

Top module: `pkt_ser_tx`

## Requirements
- R1: After reset, `line_oe` is 0, `line_out` is 1 (idle J level), `line_se0` is 0, `pkt_rdy` is 1 and `in_ready` is 0.
- R2: Every packet begins with the pattern 0x80 sent least significant bit first (seven zeros, then a one).
- R3: The second byte sent is the identifier {~type, type}, with the type in bits 3:0 and its bitwise complement in bits 7:4, least significant bit first. For example, type 4'b1000 gives 8'b0111_1000.
- R4: Class 2'b01 is a token. It sends exactly `TOKEN_BITS` (11) payload bits: all 8 bits of the first accepted byte, then bits 2:0 of the second, each byte LSB first. It accepts exactly two bytes and ignores `in_last`.
- R5: A token appends a 5-bit code with polynomial x^5+x^2+1 (0x05). The register starts at all ones and is updated over the payload bits only. It is sent complemented, most significant bit first.
- R6: Class 2'b10 is a data packet. It sends every accepted byte LSB first, up to and including the byte marked with `in_last`. It then appends a 16-bit code with polynomial x^16+x^15+x^2+1 (0x8005), with the same all-ones start, complement and MSB-first order.
- R7: Class 2'b00 (and the reserved 2'b11) is a handshake packet. It sends only the synchronisation and identifier bytes. `in_ready` stays 0 throughout.
- R8: NRZI coding: starting from the idle level 1, a zero bit toggles `line_out` and a one bit holds it.
- R9: After six consecutive one bits, an extra zero bit is inserted. Any zero, stuffed or not, restarts the count. This applies across field boundaries, including after the last code bit.
- R10: After the last bit, the line shows two symbols with `line_se0`=1 and `line_out`=0, then one symbol with `line_out`=1. After that, `line_oe` returns to 0 and `pkt_rdy` is 1.
- R11: Each line symbol holds for exactly `BIT_DIV` clock cycles. `line_out`, `line_se0` and `line_oe` change only at symbol boundaries.
- R12: A token or data packet whose byte buffer is still empty when the identifier byte ends sends no payload. The code follows at once; for data this is 16 zero bits.
- R13: While a packet is in progress, `pkt_rdy` is 0 and a `pkt_start` pulse is ignored: the packet in flight is unchanged and no further packet follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Start request, taken when `pkt_rdy` is 1 |
| pkt_type | input | 4 | Packet type placed in the identifier |
| pkt_kind | input | 2 | Class: 00 handshake, 01 token, 10 data, 11 handshake |
| pkt_rdy | output | 1 | Block idle, start will be accepted |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of a data packet |
| in_ready | output | 1 | Block can accept a payload byte |
| line_out | output | 1 | Single-ended coded line level |
| line_se0 | output | 1 | Line is in the single-ended-zero state |
| line_oe | output | 1 | Line is being driven |

## Verification
The hardest condition to reach from the ports is a stuffed bit that has to be inserted exactly at a field boundary. Examples are a run of ones spanning the identifier and the payload, or a run that ends on the last code bit just before the end-of-packet symbols. All-ones token and data payloads are used to drive long one-runs into these boundaries, and every line symbol is compared with a stream the bench derives itself. A second hard case is a start request landing mid-packet. The bench issues one while a long data packet is on the line, then checks that the stream is unchanged and that the line stays quiet afterwards.

// File: rtl/pst_pkg.sv
package pst_pkg;

   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] SYNC_PAT = 8'h80;

   typedef enum logic [1:0] {
      KIND_HS   = 2'b00,
      KIND_TOK  = 2'b01,
      KIND_DATA = 2'b10,
      KIND_RSV  = 2'b11
   } pkt_kind_e;

   typedef enum logic [1:0] {
      SYM_DATA = 2'b00,
      SYM_SE0  = 2'b01,
      SYM_J    = 2'b10
   } sym_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_SYNC,
      FS_PID,
      FS_PAY,
      FS_CRC,
      FS_EOP1,
      FS_EOP2,
      FS_JBIT
   } fst_e;

endpackage

// File: rtl/pst_bitclk.sv
// Symbol-rate tick generator. A free-running divider; with DIV of 1 every
// cycle is a symbol.
module pst_bitclk #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_full_rate
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/pst_crc.sv
// Serial check-code register: MSB-first division, preset to all ones,
// also usable as a shift register to emit its contents.
module pst_crc #(
   parameter int            W    = 5,
   parameter logic [W-1:0]  POLY = 5'h05
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic upd,
   input  logic din,
   input  logic shf,
   output logic msb
);
   logic [W-1:0] c;
   logic         fb;

   assign fb  = c[W-1] ^ din;
   assign msb = c[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c <= '1;
      end else if (clr) begin
         c <= '1;
      end else if (upd) begin
         c <= {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end else if (shf) begin
         c <= {c[W-2:0], 1'b1};
      end
   end
endmodule

// File: rtl/pst_linecode.sv
// Bit stuffer and NRZI line coder. A pending stuffed zero stalls the framer.
module pst_linecode
   import pst_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   input  sym_e sym,
   input  logic sym_bit,
   output logic take,
   output logic line,
   output logic se0,
   output logic oe
);
   localparam int OW = $clog2(STUFF_RUN + 1);
   localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);

   logic [OW-1:0] ones;
   logic          stuff_due;

   assign stuff_due = (ones == RUN_MAX);
   assign take      = tick && active && !stuff_due;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= 1'b1;
         se0  <= 1'b0;
         oe   <= 1'b0;
         ones <= '0;
      end else if (tick) begin
         if (!active) begin
            line <= 1'b1;
            se0  <= 1'b0;
            oe   <= 1'b0;
            ones <= '0;
         end else if (stuff_due) begin
            line <= ~line;
            se0  <= 1'b0;
            oe   <= 1'b1;
            ones <= '0;
         end else begin
            oe <= 1'b1;
            unique case (sym)
               SYM_DATA: begin
                  se0 <= 1'b0;
                  if (sym_bit) begin
                     ones <= ones + 1'b1;
                  end else begin
                     ones <= '0;
                     line <= ~line;
                  end
               end
               SYM_SE0: begin
                  se0  <= 1'b1;
                  line <= 1'b0;
                  ones <= '0;
               end
               SYM_J: begin
                  se0  <= 1'b0;
                  line <= 1'b1;
                  ones <= '0;
               end
               default: begin
                  se0  <= 1'b0;
                  line <= 1'b1;
                  ones <= '0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/pst_framer.sv
// Packet sequencer: sync, identifier, payload with a one-byte intake
// buffer, check code, end-of-packet symbols.
module pst_framer
   import pst_pkg::*;
#(
   parameter int TOKEN_BITS = 11,
   parameter int CRC_S_W    = 5,
   parameter int CRC_L_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        ptype,
   input  pkt_kind_e         pkind,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              take,
   input  logic              crc_s_msb,
   input  logic              crc_l_msb,
   output logic              rdy,
   output logic              active,
   output sym_e              sym,
   output logic              sym_bit,
   output logic              crc_clr,
   output logic              crc_upd,
   output logic              crc_din,
   output logic              crc_shf
);
   localparam int TOK_BYTES = (TOKEN_BITS + BYTE_W - 1) / BYTE_W;
   localparam int TBW       = $clog2(TOK_BYTES + 1);
   localparam int PCW       = $clog2(TOKEN_BITS + 1);
   localparam logic [PCW-1:0] PAY_END  = PCW'(TOKEN_BITS - 1);
   localparam logic [TBW-1:0] TOK_LAST = TBW'(TOK_BYTES - 1);
   localparam logic [3:0]     S_END    = 4'(CRC_S_W - 1);
   localparam logic [3:0]     L_END    = 4'(CRC_L_W - 1);
   localparam logic [3:0]     B_END    = 4'(BYTE_W - 1);

   fst_e              st;
   pkt_kind_e         kind_q;
   logic [3:0]        type_q;
   logic [BYTE_W-1:0] sr;
   logic [3:0]        cnt;
   logic [PCW-1:0]    paycnt;
   logic [TBW-1:0]    tok_cnt;
   logic              nb_valid;
   logic [BYTE_W-1:0] nb_data;
   logic              nb_last;
   logic              cur_last;
   logic              got_last;

   logic has_pay, accepting, in_fire, is_tok, code_end, crc_msb;

   assign is_tok    = (kind_q == KIND_TOK);
   assign has_pay   = is_tok || (kind_q == KIND_DATA);
   assign accepting = ((st == FS_SYNC) || (st == FS_PID) || (st == FS_PAY))
                      && has_pay && !got_last;
   assign in_ready  = accepting && !nb_valid;
   assign in_fire   = in_ready && in_valid;
   assign rdy       = (st == FS_IDLE);
   assign active    = (st != FS_IDLE);
   assign crc_msb   = is_tok ? crc_s_msb : crc_l_msb;
   assign code_end  = is_tok ? (cnt == S_END) : (cnt == L_END);

   always_comb begin
      unique case (st)
         FS_EOP1, FS_EOP2: sym = SYM_SE0;
         FS_JBIT:          sym = SYM_J;
         default:          sym = SYM_DATA;
      endcase
   end

   assign sym_bit = (st == FS_CRC) ? ~crc_msb : sr[0];
   assign crc_clr = (st == FS_IDLE) && start;
   assign crc_upd = take && (st == FS_PAY);
   assign crc_din = sr[0];
   assign crc_shf = take && (st == FS_CRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FS_IDLE;
         kind_q   <= KIND_HS;
         type_q   <= '0;
         sr       <= '0;
         cnt      <= '0;
         paycnt   <= '0;
         tok_cnt  <= '0;
         nb_valid <= 1'b0;
         nb_data  <= '0;
         nb_last  <= 1'b0;
         cur_last <= 1'b0;
         got_last <= 1'b0;
      end else begin
         if (in_fire) begin
            nb_valid <= 1'b1;
            nb_data  <= in_data;
            nb_last  <= in_last;
            tok_cnt  <= tok_cnt + 1'b1;
            if (((kind_q == KIND_DATA) && in_last) ||
                (is_tok && (tok_cnt == TOK_LAST))) begin
               got_last <= 1'b1;
            end
         end
         if (st == FS_IDLE) begin
            if (start) begin
               st       <= FS_SYNC;
               kind_q   <= pkind;
               type_q   <= ptype;
               sr       <= SYNC_PAT;
               cnt      <= '0;
               tok_cnt  <= '0;
               got_last <= 1'b0;
               nb_valid <= 1'b0;
            end
         end else if (take) begin
            unique case (st)
               FS_SYNC: begin
                  sr  <= sr >> 1;
                  cnt <= cnt + 1'b1;
                  if (cnt == B_END) begin
                     sr  <= {~type_q, type_q};
                     cnt <= '0;
                     st  <= FS_PID;
                  end
               end
               FS_PID: begin
                  sr  <= sr >> 1;
                  cnt <= cnt + 1'b1;
                  if (cnt == B_END) begin
                     cnt <= '0;
                     if (!has_pay) begin
                        st <= FS_EOP1;
                     end else if (nb_valid) begin
                        st       <= FS_PAY;
                        sr       <= nb_data;
                        cur_last <= nb_last;
                        nb_valid <= 1'b0;
                        paycnt   <= '0;
                     end else begin
                        st <= FS_CRC;
                     end
                  end
               end
               FS_PAY: begin
                  sr     <= sr >> 1;
                  cnt    <= cnt + 1'b1;
                  paycnt <= paycnt + 1'b1;
                  if (is_tok && (paycnt == PAY_END)) begin
                     cnt <= '0;
                     st  <= FS_CRC;
                  end else if (cnt == B_END) begin
                     cnt <= '0;
                     if ((kind_q == KIND_DATA) && cur_last) begin
                        st <= FS_CRC;
                     end else if (nb_valid) begin
                        sr       <= nb_data;
                        cur_last <= nb_last;
                        nb_valid <= 1'b0;
                     end else begin
                        st <= FS_CRC;
                     end
                  end
               end
               FS_CRC: begin
                  cnt <= cnt + 1'b1;
                  if (code_end) begin
                     cnt <= '0;
                     st  <= FS_EOP1;
                  end
               end
               FS_EOP1: st <= FS_EOP2;
               FS_EOP2: st <= FS_JBIT;
               FS_JBIT: st <= FS_IDLE;
               default: st <= FS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pkt_ser_tx.sv
module pkt_ser_tx
   import pst_pkg::*;
#(
   parameter int                  BIT_DIV    = 4,
   parameter int                  STUFF_RUN  = 6,
   parameter int                  TOKEN_BITS = 11,
   parameter int                  CRC_S_W    = 5,
   parameter int                  CRC_L_W    = 16,
   parameter logic [CRC_S_W-1:0]  CRC_S_POLY = 5'h05,
   parameter logic [CRC_L_W-1:0]  CRC_L_POLY = 16'h8005
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pkt_start,
   input  logic [3:0] pkt_type,
   input  logic [1:0] pkt_kind,
   output logic       pkt_rdy,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   output logic       line_out,
   output logic       line_se0,
   output logic       line_oe
);
   if (BIT_DIV < 1) begin : g_chk_div
      $error("BIT_DIV must be at least 1");
   end
   if (STUFF_RUN < 1) begin : g_chk_run
      $error("STUFF_RUN must be at least 1");
   end
   if ((TOKEN_BITS < 1) || (TOKEN_BITS > 16)) begin : g_chk_tok
      $error("TOKEN_BITS must lie in 1..16");
   end
   if ((CRC_S_W < 2) || (CRC_S_W > 16) || (CRC_L_W < 2) || (CRC_L_W > 16)) begin : g_chk_crc
      $error("check code widths must lie in 2..16");
   end

   logic bit_tick;
   logic take, active, sym_bit;
   sym_e sym;
   logic crc_clr, crc_upd, crc_din, crc_shf;
   logic crc_s_msb, crc_l_msb;

   pst_bitclk #(.DIV(BIT_DIV)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (bit_tick)
   );

   pst_framer #(
      .TOKEN_BITS(TOKEN_BITS),
      .CRC_S_W   (CRC_S_W),
      .CRC_L_W   (CRC_L_W)
   ) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (pkt_start),
      .ptype    (pkt_type),
      .pkind    (pkt_kind_e'(pkt_kind)),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_ready (in_ready),
      .take     (take),
      .crc_s_msb(crc_s_msb),
      .crc_l_msb(crc_l_msb),
      .rdy      (pkt_rdy),
      .active   (active),
      .sym      (sym),
      .sym_bit  (sym_bit),
      .crc_clr  (crc_clr),
      .crc_upd  (crc_upd),
      .crc_din  (crc_din),
      .crc_shf  (crc_shf)
   );

   pst_crc #(.W(CRC_S_W), .POLY(CRC_S_POLY)) u_crc_s (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .upd  (crc_upd),
      .din  (crc_din),
      .shf  (crc_shf),
      .msb  (crc_s_msb)
   );

   pst_crc #(.W(CRC_L_W), .POLY(CRC_L_POLY)) u_crc_l (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .upd  (crc_upd),
      .din  (crc_din),
      .shf  (crc_shf),
      .msb  (crc_l_msb)
   );

   pst_linecode #(.STUFF_RUN(STUFF_RUN)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (bit_tick),
      .active (active),
      .sym    (sym),
      .sym_bit(sym_bit),
      .take   (take),
      .line   (line_out),
      .se0    (line_se0),
      .oe     (line_oe)
   );
endmodule

// File: rtl/pst_chk.sv
module pst_chk #(
   parameter int STUFF_RUN = 6
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic pkt_start,
   input logic pkt_rdy,
   input logic in_ready,
   input logic line_out,
   input logic line_se0,
   input logic line_oe
);
   logic       tick_q;
   logic       prev_line;
   logic [4:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q    <= 1'b0;
         prev_line <= 1'b1;
         run       <= '0;
      end else begin
         tick_q <= tick;
         if (tick_q) begin
            prev_line <= line_out;
            if (!line_oe || line_se0) begin
               run <= '0;
            end else if (line_out == prev_line) begin
               run <= run + 1'b1;
            end else begin
               run <= '0;
            end
         end
      end
   end

   a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe |-> (line_out && !line_se0));

   a_r10_se0_low: assert property (@(posedge clk) disable iff (!rst_n)
      line_se0 |-> (!line_out && line_oe));

   a_r11_symbol_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> ($stable(line_out) && $stable(line_se0) && $stable(line_oe)));

   a_r9_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
      run <= 5'(STUFF_RUN));

   a_r13_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && pkt_rdy) |=> !pkt_rdy);

   a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !pkt_rdy);
endmodule

bind pkt_ser_tx pst_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (bit_tick),
   .pkt_start(pkt_start),
   .pkt_rdy  (pkt_rdy),
   .in_ready (in_ready),
   .line_out (line_out),
   .line_se0 (line_se0),
   .line_oe  (line_oe)
);

// File: tb/sim_pkt_ser_tx.sv
module sim_pkt_ser_tx;
   localparam int D    = 4;
   localparam int TOKB = 11;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pkt_start;
   logic [3:0] pkt_type;
   logic [1:0] pkt_kind;
   logic       pkt_rdy;
   logic       in_valid;
   logic [7:0] in_data;
   logic       in_last;
   logic       in_ready;
   logic       line_out, line_se0, line_oe;

   always #4 clk = ~clk;

   pkt_ser_tx #(.BIT_DIV(D)) u0 (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_type(pkt_type),
      .pkt_kind(pkt_kind), .pkt_rdy(pkt_rdy), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .line_out(line_out), .line_se0(line_se0), .line_oe(line_oe)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] pay [0:15];
   int         pay_n;
   int         last_at;
   bit         rawb [0:511];
   int         nraw;
   bit         el [0:1023];
   bit         es [0:1023];
   int         nsym;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void put(input bit b);
      rawb[nraw] = b;
      nraw++;
   endfunction

   task automatic build(input logic [3:0] t, input logic [1:0] k);
      logic [7:0]  pid;
      logic [15:0] c, mask, poly;
      int          w, nbits, ones;
      bit          lvl, fb, b;
      nraw = 0;
      for (int i = 0; i < 8; i++) put(((8'h80 >> i) & 8'h1) != 0);
      pid = {~t, t};
      for (int i = 0; i < 8; i++) put(pid[i]);
      if (k == 2'b01 || k == 2'b10) begin
         w     = (k == 2'b01) ? 5 : 16;
         poly  = (k == 2'b01) ? 16'h0005 : 16'h8005;
         mask  = 16'hFFFF >> (16 - w);
         c     = mask;
         nbits = 8 * pay_n;
         if (k == 2'b01 && nbits > TOKB) nbits = TOKB;
         for (int j = 0; j < nbits; j++) begin
            b  = pay[j / 8][j % 8];
            put(b);
            fb = c[w-1] ^ b;
            c  = (c << 1) & mask;
            if (fb) c = c ^ poly;
         end
         for (int j = w - 1; j >= 0; j--) put(~c[j]);
      end
      lvl = 1'b1; ones = 0; nsym = 0;
      for (int i = 0; i < nraw; i++) begin
         if (!rawb[i]) lvl = ~lvl;
         el[nsym] = lvl; es[nsym] = 1'b0; nsym++;
         if (rawb[i]) ones++; else ones = 0;
         if (ones == 6) begin
            lvl = ~lvl;
            el[nsym] = lvl; es[nsym] = 1'b0; nsym++;
            ones = 0;
         end
      end
      for (int i = 0; i < 2; i++) begin
         el[nsym] = 1'b0; es[nsym] = 1'b1; nsym++;
      end
      el[nsym] = 1'b1; es[nsym] = 1'b0; nsym++;
   endtask

   task automatic run_pkt(input logic [3:0] t, input logic [1:0] k,
                          input string tag, input bit intrude);
      build(t, k);
      @(negedge clk);
      chk(pkt_rdy, {tag, " R1 ready before start"}, pkt_rdy, 1);
      pkt_start = 1'b1; pkt_type = t; pkt_kind = k;
      @(negedge clk);
      pkt_start = 1'b0;
      fork
         begin
            if (k == 2'b01 || k == 2'b10) begin
               for (int i = 0; i < pay_n; i++) begin
                  in_valid = 1'b1; in_data = pay[i]; in_last = (i == last_at);
                  while (!in_ready) @(negedge clk);
                  @(negedge clk);
               end
            end
            in_valid = 1'b0; in_last = 1'b0;
         end
         begin
            int wt = 0;
            while (!line_oe && wt < 200) begin @(negedge clk); wt++; end
            chk(line_oe, {tag, " R11 line starts"}, line_oe, 1);
            for (int s = 0; s < nsym; s++) begin
               bit l0, s0;
               for (int c = 0; c < D; c++) begin
                  if (c == 0) begin
                     l0 = line_out; s0 = line_se0;
                     chk(line_out == el[s] && line_se0 == es[s] && line_oe,
                         $sformatf("%s R8 symbol %0d", tag, s),
                         {line_se0, line_out}, {es[s], el[s]});
                  end
                  if (c == D - 1)
                     chk(line_out == l0 && line_se0 == s0,
                         $sformatf("%s R11 hold symbol %0d", tag, s), line_out, l0);
                  if ((k == 2'b00 || k == 2'b11) && in_ready)
                     chk(1'b0, {tag, " R7 in_ready during handshake"}, 1, 0);
                  @(negedge clk);
               end
            end
            chk(!line_oe && line_out && !line_se0 && pkt_rdy,
                {tag, " R10 idle after end"}, {pkt_rdy, line_oe, line_out, line_se0}, 4'b1010);
         end
         begin
            if (intrude) begin
               repeat (30) @(negedge clk);
               chk(!pkt_rdy, {tag, " R13 busy mid-packet"}, pkt_rdy, 0);
               pkt_start = 1'b1; pkt_type = 4'h5; pkt_kind = 2'b00;
               @(negedge clk);
               pkt_start = 1'b0;
            end
         end
      join
      if (intrude) begin
         repeat (4 * D) @(negedge clk);
         chk(!line_oe && pkt_rdy, {tag, " R13 no extra packet"}, line_oe, 0);
      end
   endtask

   task automatic t_reset();
      chk(line_out == 1'b1, "R1 reset line", line_out, 1);
      chk(!line_se0, "R1 reset se0", line_se0, 0);
      chk(!line_oe, "R1 reset oe", line_oe, 0);
      chk(pkt_rdy, "R1 reset ready", pkt_rdy, 1);
      chk(!in_ready, "R1 reset in_ready", in_ready, 0);
   endtask

   task automatic t_handshake();
      pay_n = 0; last_at = -1;
      run_pkt(4'b0010, 2'b00, "R2 R3 R7 handshake", 1'b0);
      run_pkt(4'b1000, 2'b11, "R3 R7 reserved class", 1'b0);
   endtask

   task automatic t_token();
      pay[0] = 8'hA3; pay[1] = 8'hFD; pay_n = 2; last_at = -1;
      run_pkt(4'b1101, 2'b01, "R4 R5 token", 1'b0);
      pay[0] = 8'hFF; pay[1] = 8'hFF; pay_n = 2; last_at = 0;
      run_pkt(4'b1001, 2'b01, "R4 R9 token ones last ignored", 1'b0);
   endtask

   task automatic t_data();
      pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03; pay[3] = 8'h40;
      pay_n = 4; last_at = 3;
      run_pkt(4'b0011, 2'b10, "R6 data", 1'b0);
   endtask

   task automatic t_data_stuff();
      pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7F;
      pay_n = 3; last_at = 2;
      run_pkt(4'b1011, 2'b10, "R9 data stuffing", 1'b0);
   endtask

   task automatic t_zero_len();
      pay_n = 0; last_at = -1;
      run_pkt(4'b0011, 2'b10, "R12 zero-length data", 1'b0);
   endtask

   task automatic t_busy();
      for (int i = 0; i < 8; i++) pay[i] = 8'(8'h11 * (i + 1));
      pay_n = 8; last_at = 7;
      run_pkt(4'b0011, 2'b10, "R13 start while busy", 1'b1);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 200000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      rst_n = 1'b0; pkt_start = 1'b0; pkt_type = '0; pkt_kind = '0;
      in_valid = 1'b0; in_data = '0; in_last = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_handshake();
      t_token();
      t_data();
      t_data_stuff();
      t_zero_len();
      t_busy();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule